// File: doc/BRIEF.md
# Tuning PLL Divider and Phase Comparator

This block is the digital heart of a frequency-synthesiser tuning loop for a varicap-tuned oscillator. A reference divider turns the 4 MHz crystal clock into the comparison rate. A programmable counter divides the output of an external fixed divide-by-8 prescaler by a ratio that a serial receiver supplies. A two-state phase/frequency comparator turns the timing difference between the two comparison-rate events into pump-up and pump-down pulses for an external charge pump. A lock detector reports when those pulses have stayed narrow for several comparison periods in a row.

Two step modes are selected by `mode_sel`. With `mode_sel` = 0 the reference divides by 512, giving 7.8125 kHz, and the ratio is 14 bits wide. With the prescaler's factor of 8 the tuning step is then 62.5 kHz. With `mode_sel` = 1 the reference divides by 640, giving 6.25 kHz, and the full 15-bit ratio is used, for a 50 kHz step. The whole block runs on the crystal clock. Each prescaler output edge arrives as a one-cycle strobe on `pre_pulse`, already brought into that clock domain.

The lock flag models an open-drain pin: `lock_oe` = 1 pulls the pin (locked) and 0 releases it to high impedance (out of lock). Two disable inputs silence the pump outputs and switch off the varactor drive enable.

Top module: `tpll_core`

## Requirements
- R1: `fcomp_o` is a one-cycle pulse whose period is 512 clocks when `mode_sel`=0 and 640 clocks when `mode_sel`=1. The first pulse appears on the 512th or 640th clock edge after reset is released.
- R2: `fpd_o` is a one-cycle pulse issued once every R strobes of `pre_pulse`, where R is the effective ratio. When `mode_sel`=0, R is `ratio_i[13:0]` and bit 14 is ignored. When `mode_sel`=1, R is all 15 bits. After reset the first strobe produces a pulse in the clock that follows it.
- R3: An effective ratio of 0 or 1 behaves as a ratio of 2.
- R4: A new `ratio_i` value takes effect only at the next `fpd_o` event. The division period already in progress completes with the old ratio.
- R5: When an `fcomp_o` event comes before the matching `fpd_o` event, `cp_up` goes high in the cycle after `fcomp_o` and stays high for exactly as many cycles as `fpd_o` lags. When `fpd_o` comes first, `cp_dn` behaves the same way. When both events fall in the same cycle, no pulse is produced. `cp_up` and `cp_dn` are never high together.
- R6: While `cp_dis`=1, `cp_up` and `cp_dn` are both held low. When it returns to 0, pulses resume.
- R7: `drv_en` follows the inverse of `drv_dis`, one clock later.
- R8: `lock_oe` rises in the cycle after the 8th consecutive comparison period, counted at `fcomp_o`, in which no pump pulse lasted more than 4 clocks. It falls in the cycle after any pump pulse has been high for a 5th consecutive clock.
- R9: While `rst_n` is low, `cp_up`, `cp_dn`, `drv_en`, `lock_oe`, `fcomp_o` and `fpd_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 MHz crystal-derived clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | Step mode: 0 = divide-by-512 and 14-bit ratio, 1 = divide-by-640 and 15-bit ratio |
| ratio_i | input | 15 | Division ratio from the serial receiver |
| pre_pulse | input | 1 | One-cycle strobe per prescaler output edge |
| cp_dis | input | 1 | Forces both pump outputs inactive |
| drv_dis | input | 1 | Turns off the varactor drive enable |
| cp_up | output | 1 | Charge-pump source pulse |
| cp_dn | output | 1 | Charge-pump sink pulse |
| drv_en | output | 1 | Varactor drive amplifier enable |
| lock_oe | output | 1 | Lock pin pull-down enable (1 = locked) |
| fcomp_o | output | 1 | Reference comparison-rate pulse |
| fpd_o | output | 1 | Divided-signal comparison-rate pulse |

## Verification
On every cycle the assertions check the following: a reference pulse never repeats in the next cycle, a divider pulse always follows a strobe, the count decrements steadily and never reloads below two, the two pump states are never high together and each starts only on its own event, lock rises only at a comparison boundary and drops after an over-wide pulse, and the disable inputs hold. The exact periods in both modes, the bit-14 masking, the delayed ratio reload, the measured pump widths against event spacing, the coincident-edge case and the eight-period lock count can only be shown by the bench's directed scenarios.

// File: rtl/tpll_pkg.sv
package tpll_pkg;

  // Step mode selected by the mode input.
  typedef enum logic {
    STEP_COARSE = 1'b0,  // divide-by-512, 14-bit ratio
    STEP_FINE   = 1'b1   // divide-by-640, 15-bit ratio
  } step_mode_e;

  // Phase comparator state.
  typedef struct packed {
    logic up;
    logic dn;
  } pump_t;

endpackage

// File: rtl/tpll_ref_div.sv
module tpll_ref_div #(
  parameter int DIV_A = 512,
  parameter int DIV_B = 640
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_b,
  output logic tick_o
);
  localparam int DMAX = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int CW   = $clog2(DMAX);

  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          tick_q, tick_d;

  assign lim = sel_b ? CW'(DIV_B - 1) : CW'(DIV_A - 1);

  always_comb begin
    tick_d = (cnt_q >= lim);
    cnt_d  = tick_d ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q);
  a_r1_wrap_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> (cnt_q == '0));
endmodule

// File: rtl/tpll_prog_div.sv
module tpll_prog_div #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_b,
  input  logic [W-1:0] ratio_i,
  input  logic         adv_i,
  output logic         div_o
);
  logic [W-1:0] masked, eff;
  logic [W-1:0] cnt_q, cnt_d;
  logic         term, div_q, div_d;

  // Top ratio bit only counts in the wide mode.
  for (genvar i = 0; i < W; i++) begin : g_mask
    if (i == W - 1) begin : g_top
      assign masked[i] = ratio_i[i] & sel_b;
    end else begin : g_low
      assign masked[i] = ratio_i[i];
    end
  end

  assign eff  = (masked < W'(2)) ? W'(2) : masked;
  assign term = (cnt_q <= W'(1));

  always_comb begin
    cnt_d = term ? eff : cnt_q - W'(1);
    div_d = adv_i & term;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else begin
      if (adv_i) cnt_q <= cnt_d;
      div_q <= div_d;
    end
  end

  assign div_o = div_q;

  a_r2_pulse_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    div_q |-> $past(adv_i));
  a_r4_steady_count: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && cnt_q > W'(1)) |=> (cnt_q == $past(cnt_q) - W'(1)));
  a_r3_reload_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && term) |=> (cnt_q >= W'(2)));
endmodule

// File: rtl/tpll_pfd.sv
module tpll_pfd
  import tpll_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ref_i,
  input  logic  div_i,
  output pump_t pump_o
);
  pump_t st_q, st_d;
  logic  up_set, dn_set, both;

  always_comb begin
    up_set = st_q.up | ref_i;
    dn_set = st_q.dn | div_i;
    both   = up_set & dn_set;
    st_d.up = up_set & ~both;
    st_d.dn = dn_set & ~both;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign pump_o = st_q;

  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_q.up && st_q.dn));
  a_r5_up_on_ref: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q.up) |-> $past(ref_i));
  a_r5_dn_on_div: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q.dn) |-> $past(div_i));
  a_r5_up_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.up && div_i) |=> !st_q.up);
endmodule

// File: rtl/tpll_lock_det.sv
module tpll_lock_det #(
  parameter int COUNT = 8,
  parameter int WIN   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_i,
  input  logic active_i,
  output logic lock_o
);
  localparam int WCW = $clog2(WIN + 1);
  localparam int GCW = $clog2(COUNT + 1);

  logic [WCW-1:0] w_q, w_d;
  logic [GCW-1:0] good_q, good_d;
  logic           viol;

  always_comb begin
    viol = active_i && (w_q == WCW'(WIN));
    if (!active_i)              w_d = '0;
    else if (w_q == WCW'(WIN))  w_d = w_q;
    else                        w_d = w_q + WCW'(1);

    if (viol)                                   good_d = '0;
    else if (ref_i && good_q != GCW'(COUNT))    good_d = good_q + GCW'(1);
    else                                        good_d = good_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q    <= '0;
      good_q <= '0;
    end else begin
      w_q    <= w_d;
      good_q <= good_d;
    end
  end

  assign lock_o = (good_q == GCW'(COUNT));

  a_r8_rise_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(ref_i));
  a_r8_drop_on_wide: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && w_q == WCW'(WIN)) |=> !lock_o);
endmodule

// File: rtl/tpll_core.sv
module tpll_core
  import tpll_pkg::*;
#(
  parameter int REF_DIV_A  = 512,
  parameter int REF_DIV_B  = 640,
  parameter int RATIO_W    = 15,
  parameter int LOCK_COUNT = 8,
  parameter int LOCK_WIN   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_sel,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               pre_pulse,
  input  logic               cp_dis,
  input  logic               drv_dis,
  output logic               cp_up,
  output logic               cp_dn,
  output logic               drv_en,
  output logic               lock_oe,
  output logic               fcomp_o,
  output logic               fpd_o
);
  step_mode_e mode;
  pump_t      pump;
  logic       ref_t, div_t, drv_q;

  assign mode = step_mode_e'(mode_sel);

  tpll_ref_div #(.DIV_A(REF_DIV_A), .DIV_B(REF_DIV_B)) u_ref (
    .clk(clk), .rst_n(rst_n), .sel_b(mode == STEP_FINE), .tick_o(ref_t));

  tpll_prog_div #(.W(RATIO_W)) u_div (
    .clk(clk), .rst_n(rst_n), .sel_b(mode == STEP_FINE), .ratio_i(ratio_i),
    .adv_i(pre_pulse), .div_o(div_t));

  tpll_pfd u_pfd (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_t), .div_i(div_t), .pump_o(pump));

  tpll_lock_det #(.COUNT(LOCK_COUNT), .WIN(LOCK_WIN)) u_lock (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_t), .active_i(pump.up | pump.dn),
    .lock_o(lock_oe));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_q <= 1'b0;
    else        drv_q <= ~drv_dis;
  end

  assign cp_up   = pump.up & ~cp_dis;
  assign cp_dn   = pump.dn & ~cp_dis;
  assign drv_en  = drv_q;
  assign fcomp_o = ref_t;
  assign fpd_o   = div_t;

  a_r6_pump_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cp_dis |-> (!cp_up && !cp_dn));
  a_r7_drive_off: assert property (@(posedge clk) disable iff (!rst_n)
    $past(drv_dis) |-> !drv_en);
endmodule

// File: tb/tb_tpll_core.sv
module tb_tpll_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_sel = 1'b0;
  logic [14:0] ratio = 15'd512;
  logic        pre_pulse = 1'b0;
  logic        cp_dis = 1'b0;
  logic        drv_dis = 1'b0;
  logic        cp_up, cp_dn, drv_en, lock_oe, fcomp_o, fpd_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  tpll_core dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ratio_i(ratio),
    .pre_pulse(pre_pulse), .cp_dis(cp_dis), .drv_dis(drv_dis),
    .cp_up(cp_up), .cp_dn(cp_dn), .drv_en(drv_en), .lock_oe(lock_oe),
    .fcomp_o(fcomp_o), .fpd_o(fpd_o));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic msel, input logic [14:0] r);
    @(negedge clk);
    rst_n = 1'b0; pre_pulse = 1'b0; cp_dis = 1'b0; drv_dis = 1'b0;
    mode_sel = msel; ratio = r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_fcomp(input int limit, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!fcomp_o && n < limit);
  endtask

  task automatic wait_fpd(input int limit, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!fpd_o && n < limit);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst_n = 1'b0; drv_dis = 1'b0; pre_pulse = 1'b1;
    repeat (3) @(negedge clk);
    chk({cp_up, cp_dn, drv_en, lock_oe, fcomp_o, fpd_o} == 6'b0, "R9 outputs in reset",
        int'({cp_up, cp_dn, drv_en, lock_oe, fcomp_o, fpd_o}), 0);
    pre_pulse = 1'b0;
  endtask

  task automatic t_ref_period(input logic msel, input int exp);
    int n;
    do_reset(msel, 15'd512);
    wait_fcomp(2000, n);
    chk(n == exp, "R1 first reference pulse", n, exp);
    @(negedge clk);
    chk(fcomp_o == 1'b0, "R1 pulse width one cycle", int'(fcomp_o), 0);
    wait_fcomp(2000, n);
    chk(n + 1 == exp, "R1 reference period", n + 1, exp);
  endtask

  task automatic t_div(input logic msel, input logic [14:0] r, input int exp, input string tag);
    int n;
    do_reset(msel, r);
    pre_pulse = 1'b1;
    wait_fpd(40000, n);
    chk(n == 1, {tag, " first pulse"}, n, 1);
    wait_fpd(40000, n);
    chk(n == exp, tag, n, exp);
    pre_pulse = 1'b0;
  endtask

  task automatic t_reload();
    int n;
    do_reset(1'b1, 15'd100);
    pre_pulse = 1'b1;
    wait_fpd(1000, n);
    wait_fpd(1000, n);
    repeat (10) @(negedge clk);
    ratio = 15'd50;
    wait_fpd(1000, n);
    chk(n + 10 == 100, "R4 current period keeps old ratio", n + 10, 100);
    wait_fpd(1000, n);
    chk(n == 50, "R4 new ratio after terminal", n, 50);
    pre_pulse = 1'b0;
  endtask

  // Divided pulse lags the reference: up pulse, then pump disable.
  task automatic t_pfd_up();
    int n, td, up, dn;
    do_reset(1'b0, 15'd512);
    repeat (516) @(negedge clk);
    pre_pulse = 1'b1;
    wait_fcomp(2000, n);
    td = -10; up = 0; dn = 0;
    for (int k = 1; k < 60; k++) begin
      @(negedge clk);
      if (cp_up) up++;
      if (cp_dn) dn++;
      if (fpd_o) td = k;
      if (k == td + 2) break;
    end
    chk(up == td && td > 0, "R5 up width equals lag", up, td);
    chk(dn == 0, "R5 no down pulse when lagging", dn, 0);
    cp_dis = 1'b1;
    n = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (cp_up || cp_dn) n++;
    end
    chk(n == 0, "R6 pump quiet while disabled", n, 0);
    cp_dis = 1'b0;
    n = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (cp_up) n++;
    end
    chk(n > 0, "R6 pulses resume", n, td);
    pre_pulse = 1'b0;
  endtask

  // Divided pulse leads by two clocks: down pulses, lock, then unlock.
  task automatic t_pfd_dn_lock();
    int n, tr, up, dn, nref, run;
    do_reset(1'b0, 15'd512);
    repeat (509) @(negedge clk);
    pre_pulse = 1'b1;
    nref = 0;
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      if (fcomp_o) begin
        nref++;
        if (nref == 8) begin
          chk(lock_oe == 1'b0, "R8 lock low at 8th boundary", int'(lock_oe), 0);
          @(negedge clk);
          chk(lock_oe == 1'b1, "R8 lock after 8 good periods", int'(lock_oe), 1);
          break;
        end
      end
    end
    wait_fpd(1000, n);
    tr = -10; up = 0; dn = 0;
    for (int k = 1; k < 60; k++) begin
      @(negedge clk);
      if (cp_up) up++;
      if (cp_dn) dn++;
      if (fcomp_o) tr = k;
      if (k == tr + 2) break;
    end
    chk(dn == tr && tr > 0, "R5 down width equals lead", dn, tr);
    chk(up == 0, "R5 no up pulse when leading", up, 0);
    ratio = 15'd600;
    run = 0;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      run = cp_up ? run + 1 : 0;
      if (run == 5) begin
        chk(lock_oe == 1'b1, "R8 lock held through 5th wide cycle", int'(lock_oe), 1);
        @(negedge clk);
        chk(lock_oe == 1'b0, "R8 lock dropped after wide pulse", int'(lock_oe), 0);
        break;
      end
    end
    chk(run == 5, "R8 wide pulse observed", run, 5);
    pre_pulse = 1'b0;
  endtask

  task automatic t_coincident();
    int act, both;
    do_reset(1'b0, 15'd512);
    repeat (511) @(negedge clk);
    pre_pulse = 1'b1;
    act = 0; both = 0;
    for (int k = 0; k < 1100; k++) begin
      @(negedge clk);
      if (cp_up || cp_dn) act++;
      if (fcomp_o && fpd_o) both++;
    end
    chk(both >= 2, "R5 events coincide", both, 2);
    chk(act == 0, "R5 no pulse on coincident events", act, 0);
    pre_pulse = 1'b0;
  endtask

  task automatic t_drive();
    do_reset(1'b0, 15'd512);
    @(negedge clk);
    chk(drv_en == 1'b1, "R7 drive enabled", int'(drv_en), 1);
    drv_dis = 1'b1;
    @(negedge clk);
    chk(drv_en == 1'b0, "R7 drive disabled", int'(drv_en), 0);
    drv_dis = 1'b0;
    @(negedge clk);
    chk(drv_en == 1'b1, "R7 drive re-enabled", int'(drv_en), 1);
  endtask

  initial begin
    t_reset_state();
    t_ref_period(1'b0, 512);
    t_ref_period(1'b1, 640);
    t_div(1'b1, 15'd1000, 1000, "R2 wide mode ratio 1000");
    t_div(1'b0, 15'h4000 | 15'd300, 300, "R2 coarse mode ignores bit 14");
    t_div(1'b1, 15'h4000 | 15'd300, 16684, "R2 wide mode uses bit 14");
    t_div(1'b0, 15'd0, 2, "R3 ratio 0 acts as 2");
    t_div(1'b1, 15'd1, 2, "R3 ratio 1 acts as 2");
    t_reload();
    t_pfd_up();
    t_pfd_dn_lock();
    t_coincident();
    t_drive();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule